// File: doc/BRIEF.md
# Indexed-Access Priority Interrupt Controller

This controller sits beside a processor core and gathers up to 240 level-sensitive request lines. The lines are numbered 16 upward. Numbers below 16 belong to exceptions and never produce a request. Software does not reach each line's settings directly. It first writes a line number into a select register. After that, two data windows, one for the mask bit and one for the priority, act on that line only. The block has one small register bus with a single-cycle write strobe and a combinational read.

Each cycle the controller looks at every asserted, unmasked line and picks the most urgent one. Level 0 is the most urgent. A line can win only if its level is strictly more urgent than every level already in service. When two lines share a level, the lower number wins. The winner's number and level appear at the ports, gated by a global enable. An acknowledge pulse moves the winning level into service and records the line number. An end-of-interrupt pulse retires the most urgent level in service. This lets handlers nest, but only by strictly more urgent levels. A read-only configuration word tells software how many levels the build has.

Top module: `prio_intc`

## Requirements
- R1: After reset every line is unmasked, every priority is 0, no level is in service, and the select, cause, active and pending registers read 0.
- R2: Register addresses are: select 0, mask window 1, priority window 2, cause 3, active 4, pending 5, configuration 6. The select register keeps the low 8 bits written and reads them back. The mask and priority windows read and write only the line whose number is in select.
- R3: While select holds a number outside 16 to 15+NUM_LINES, both windows read 0 and writes to them change no line.
- R4: Writing a value with bit 0 clear to the mask window masks the selected line, so it never requests. Writing bit 0 set unmasks it. The window reads back that bit.
- R5: A priority write larger than NUM_LEVELS-1 stores NUM_LEVELS-1. Smaller writes are stored as written.
- R6: The configuration register holds NUM_LEVELS-1 in bits 27:24, and all other bits read 0.
- R7: Among eligible lines, the most urgent level wins and ties go to the lowest line number. Input bit i is line 16+i, and irq_num reports that line number.
- R8: Requests are level-sensitive. A line takes part in arbitration in exactly the cycles its input is high, and no latch holds a request after the input drops.
- R9: irq_req is high only while glb_ie is high. glb_ie does not change the pending register.
- R10: ack while irq_req is high sets bit L of the active register (bit L means level L is in service) and stores irq_num in the cause register. From then on, only levels strictly more urgent than every level in service can win.
- R11: eoi clears the lowest-numbered set bit of the active register, that is, the most urgent level in service.
- R12: Pending bit L is set while any unmasked line of level L is asserted. This holds whatever the active register and glb_ie are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Level request inputs; bit i is line 16+i |
| glb_ie | input | 1 | Global enable for request delivery |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ack | input | 1 | Core takes the current winner |
| eoi | input | 1 | Handler finished; retire the most urgent level in service |
| irq_req | output | 1 | A request is presented to the core |
| irq_num | output | 8 | Winning line number |
| irq_lvl | output | LVW | Winning line's priority level |

## Verification
Arbitration is tried with three asserted lines where two share a level below a third. This separates "most urgent level" from "lowest number" as the deciding rule. It also tries the lowest and highest line numbers raised together at one level. Nesting is driven by taking a request and then raising a line at the same level and at a more urgent level. That separates strict from non-strict nesting, and the end-of-interrupt steps then show which level is retired first. Register access is walked with two neighbouring lines and an out-of-range select. This catches windows that act on the wrong line, and writes that leak through an invalid select. Masking, dropping an input and clearing the global enable are each applied to a live winner. Each shows a different way for a request to vanish.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_LINES  = 240,
  parameter int NUM_LEVELS = 4,
  localparam int LVW = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
  localparam int IXW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 glb_ie,
  input  logic [3:0]           reg_addr,
  input  logic                 reg_we,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 ack,
  input  logic                 eoi,
  output logic                 irq_req,
  output logic [7:0]           irq_num,
  output logic [LVW-1:0]       irq_lvl
);
  localparam logic [3:0] A_SEL = 4'd0, A_ENA = 4'd1, A_PRI = 4'd2, A_CAUSE = 4'd3,
                         A_ACT = 4'd4, A_PEND = 4'd5, A_CFG = 4'd6;
  localparam logic [LVW-1:0] LVL_MAX = LVW'(NUM_LEVELS - 1);

  logic [7:0]            sel_q, cause_q;
  logic [NUM_LINES-1:0]  ena_q;
  logic [LVW-1:0]        pri_q [NUM_LINES];
  logic [NUM_LEVELS-1:0] act_q, pend, take_mask;
  logic [7:0]            sel_off;
  logic [IXW-1:0]        sel_ix, best_ix;
  logic                  sel_ok, found, take;
  logic [LVW:0]          ceil_lvl, best_lvl;
  logic [LVW-1:0]        wr_pri;

  assign sel_off = sel_q - 8'd16;
  assign sel_ix  = sel_off[IXW-1:0];
  assign sel_ok  = (sel_q >= 8'd16) && ({1'b0, sel_q} < 9'(16 + NUM_LINES));
  assign wr_pri  = (reg_wdata > 32'(NUM_LEVELS - 1)) ? LVL_MAX : reg_wdata[LVW-1:0];

  always_comb begin
    ceil_lvl = (LVW+1)'(NUM_LEVELS);
    for (int l = NUM_LEVELS - 1; l >= 0; l--)
      if (act_q[l]) ceil_lvl = (LVW+1)'(l);
  end

  always_comb begin
    found    = 1'b0;
    best_lvl = '1;
    best_ix  = '0;
    pend     = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (irq_in[i] && ena_q[i]) begin
        pend[pri_q[i]] = 1'b1;
        if ({1'b0, pri_q[i]} < ceil_lvl && (!found || {1'b0, pri_q[i]} < best_lvl)) begin
          found    = 1'b1;
          best_lvl = {1'b0, pri_q[i]};
          best_ix  = IXW'(i);
        end
      end
    end
  end

  assign irq_req   = glb_ie && found;
  assign irq_num   = found ? 8'(best_ix) + 8'd16 : 8'd0;
  assign irq_lvl   = best_lvl[LVW-1:0];
  assign take      = ack && irq_req;
  assign take_mask = take ? (NUM_LEVELS'(1) << irq_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      cause_q <= '0;
      act_q   <= '0;
      ena_q   <= '1;
      for (int i = 0; i < NUM_LINES; i++) pri_q[i] <= '0;
    end else begin
      act_q <= (eoi ? (act_q & (act_q - 1'b1)) : act_q) | take_mask;
      if (take) cause_q <= irq_num;
      if (reg_we) begin
        if (reg_addr == A_SEL) sel_q <= reg_wdata[7:0];
        if (reg_addr == A_ENA && sel_ok) ena_q[sel_ix] <= reg_wdata[0];
        if (reg_addr == A_PRI && sel_ok) pri_q[sel_ix] <= wr_pri;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_SEL:   reg_rdata = {24'd0, sel_q};
      A_ENA:   reg_rdata = {31'd0, sel_ok && ena_q[sel_ix]};
      A_PRI:   reg_rdata = sel_ok ? 32'(pri_q[sel_ix]) : 32'd0;
      A_CAUSE: reg_rdata = {24'd0, cause_q};
      A_ACT:   reg_rdata = 32'(act_q);
      A_PEND:  reg_rdata = 32'(pend);
      A_CFG:   reg_rdata = {4'd0, 4'(NUM_LEVELS - 1), 24'd0};
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NUM_LINES  = 240,
  parameter int NUM_LEVELS = 4,
  parameter int LVW        = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  glb_ie,
  input logic                  ack,
  input logic                  eoi,
  input logic                  irq_req,
  input logic [7:0]            irq_num,
  input logic [LVW-1:0]        irq_lvl,
  input logic [NUM_LEVELS-1:0] act_q,
  input logic [7:0]            cause_q
);
  AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glb_ie); // R9
  AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_num >= 8'd16 && {1'b0, irq_num} < 9'(16 + NUM_LINES))); // R7
  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((act_q & ((NUM_LEVELS'(2) << irq_lvl) - 1'b1)) == '0)); // R10
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (cause_q == $past(irq_num))); // R10
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && act_q != '0) |=> ($countones(act_q) == $countones($past(act_q)) - 1)); // R11
  AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !eoi) |=> $stable(act_q)); // R10
endmodule

bind prio_intc prio_intc_chk #(.NUM_LINES(NUM_LINES), .NUM_LEVELS(NUM_LEVELS), .LVW(LVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_ie(glb_ie), .ack(ack), .eoi(eoi), .irq_req(irq_req),
  .irq_num(irq_num), .irq_lvl(irq_lvl), .act_q(act_q), .cause_q(cause_q)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int NL = 240;
  localparam int NV = 4;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          glb_ie = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          ack = 1'b0, eoi = 1'b0;
  logic          irq_req;
  logic [7:0]    irq_num;
  logic [LW-1:0] irq_lvl;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_intc #(.NUM_LINES(NL), .NUM_LEVELS(NV)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .glb_ie(glb_ie), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack), .eoi(eoi),
    .irq_req(irq_req), .irq_num(irq_num), .irq_lvl(irq_lvl)
  );

  // {write, addr, data, expected read}
  localparam logic [68:0] VEC [0:20] = '{
    {1'b0, 4'd0, 32'd0,   32'd0},          // R1 select
    {1'b0, 4'd6, 32'd0,   32'h0300_0000},  // R6 config
    {1'b1, 4'd0, 32'd20,  32'd0},
    {1'b0, 4'd1, 32'd0,   32'd1},          // R1 enabled
    {1'b0, 4'd2, 32'd0,   32'd0},          // R1 prio
    {1'b1, 4'd2, 32'd2,   32'd0},
    {1'b1, 4'd1, 32'd0,   32'd0},
    {1'b1, 4'd0, 32'd21,  32'd0},
    {1'b0, 4'd1, 32'd0,   32'd1},          // R2 neighbour untouched
    {1'b0, 4'd2, 32'd0,   32'd0},          // R2
    {1'b1, 4'd0, 32'd20,  32'd0},
    {1'b0, 4'd1, 32'd0,   32'd0},          // R4 masked reads back
    {1'b0, 4'd2, 32'd0,   32'd2},          // R2
    {1'b1, 4'd2, 32'd9,   32'd0},
    {1'b0, 4'd2, 32'd0,   32'd3},          // R5 clamp
    {1'b1, 4'd0, 32'h105, 32'd0},
    {1'b0, 4'd0, 32'd0,   32'd5},          // R2 low 8 bits kept
    {1'b0, 4'd1, 32'd0,   32'd0},          // R3 window zero
    {1'b1, 4'd2, 32'd1,   32'd0},
    {1'b1, 4'd0, 32'd255, 32'd0},
    {1'b0, 4'd2, 32'd0,   32'd0}           // R3 no leak, top line
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(input bit do_ack, input bit do_eoi);
    @(negedge clk);
    ack = do_ack; eoi = do_eoi;
    @(negedge clk);
    ack = 1'b0; eoi = 1'b0;
    #1;
  endtask

  task automatic win(input string req, input bit r, input logic [7:0] n);
    #1 chk(req, {23'd0, r, n}, {23'd0, irq_req, r ? irq_num : 8'd0});
  endtask

  task automatic set_line(input int ln, input int en, input int p);
    wr(4'd0, 32'(ln)); wr(4'd1, 32'(en)); wr(4'd2, 32'(p));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 21; k++) begin
      if (VEC[k][68]) wr(VEC[k][67:64], VEC[k][63:32]);
      else rd($sformatf("R2 vector %0d", k), VEC[k][67:64], VEC[k][31:0]);
    end
    rd("R1 active", 4'd4, 32'd0);
    rd("R1 cause", 4'd3, 32'd0);

    rst_n = 1'b0; #3 rst_n = 1'b1;
    glb_ie = 1'b1;
    win("R1 no request", 1'b0, 8'd0);
    set_line(30, 1, 2); set_line(40, 1, 1); set_line(50, 1, 1);
    @(negedge clk);
    irq_in[14] = 1'b1; irq_in[24] = 1'b1; irq_in[34] = 1'b1;
    win("R7 tie lowest", 1'b1, 8'd40);
    chk("R7 level", 32'(irq_lvl), 32'd1);
    rd("R12 pending", 4'd5, 32'b0110);
    glb_ie = 1'b0;
    win("R9 gated", 1'b0, 8'd0);
    rd("R9 pending kept", 4'd5, 32'b0110);
    glb_ie = 1'b1;
    pulse(1'b1, 1'b0);
    rd("R10 active", 4'd4, 32'b0010);
    rd("R10 cause", 4'd3, 32'd40);
    win("R10 same level blocked", 1'b0, 8'd0);
    rd("R12 pending while active", 4'd5, 32'b0110);
    irq_in[44] = 1'b1;
    win("R10 nest more urgent", 1'b1, 8'd60);
    pulse(1'b1, 1'b0);
    rd("R10 two active", 4'd4, 32'b0011);
    win("R10 level 0 blocked", 1'b0, 8'd0);
    pulse(1'b0, 1'b1);
    rd("R11 retire most urgent", 4'd4, 32'b0010);
    irq_in[44] = 1'b0;
    pulse(1'b0, 1'b1);
    rd("R11 empty", 4'd4, 32'd0);
    win("R8 still held", 1'b1, 8'd40);
    wr(4'd0, 32'd40); wr(4'd1, 32'd0);
    win("R4 masked", 1'b1, 8'd50);
    wr(4'd1, 32'd1);
    win("R4 unmasked", 1'b1, 8'd40);
    irq_in[24] = 1'b0; irq_in[34] = 1'b0;
    win("R8 dropped", 1'b1, 8'd30);
    irq_in[14] = 1'b0;
    win("R8 none", 1'b0, 8'd0);
    set_line(16, 1, 3); set_line(255, 1, 3);
    @(negedge clk);
    irq_in[0] = 1'b1; irq_in[NL-1] = 1'b1;
    win("R7 edge lines", 1'b1, 8'd16);
    irq_in[0] = 1'b0;
    win("R7 top line", 1'b1, 8'd255);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule